// File: doc/BRIEF.md
# Cascaded Peripheral Clock Generator

This block derives one gated peripheral clock from four reference sources. All logic runs on a single fast system clock. Each reference is presented as a one-cycle tick on `refTick`, and each tick marks one edge of that reference, rising or falling. The generated clock `clkOut` toggles after a programmed number of ticks of the selected reference. This gives a clean 50 % duty cycle for every ratio. The division ratio in ticks per half period equals the division ratio of the reference clock.

A 2-bit field selects the reference. The ratio comes from a mode field:

- **Two-stage mode:** two 3-bit divider fields are multiplied together.
- **Table modes:** one of three single-stage table modes decodes the first divider field alone.

A stop bit with disable polarity holds the output low.

Selector, ratio and gate updates only take effect while the divided clock is low. This means no shortened pulse ever appears on the output.

Top module: `periph_clk_gen`

## Requirements
- R1: While `rstN` is low, `clkOut` is low.
- R2: `cfgSel` picks the tick source `refTick[cfgSel]`: 0 = primary A, 1 = primary B, 2 = secondary A, 3 = secondary B. Each half period of `clkOut` lasts exactly ratio ticks of the chosen source.
- R3: In mode 0 (two-stage), the ratio is `cfgDivA × cfgDivB` for field values 1 to 7.
- R4: In mode 0, a field value of 0 counts as 1.
- R5: In mode 1, `cfgDivA` values 1 to 6 give ratios 1 to 6, and values 0 and 7 give ratio 1. `cfgDivB` has no effect.
- R6: In mode 2, `cfgDivA` bit 0 gives ratio 1 (bit clear) or 2 (bit set). The upper bits of `cfgDivA` and all of `cfgDivB` have no effect.
- R7: In mode 3, `cfgDivA` bit 0 gives ratio 2 (bit clear) or 4 (bit set). The upper bits and `cfgDivB` have no effect.
- R8: With `cfgGateOff` = 1 the output stays low. With 0 it runs.
- R9: Setting `cfgGateOff` during a high phase does not shorten that pulse. `clkOut` only ever rises or falls together with the internal divided clock.
- R10: A new selector or ratio is adopted only while the divided clock is low and no tick of that low phase has yet been counted. Otherwise the running phases finish with the old setting, and the new one applies from the next low phase.
- R11: The high and low phases of `clkOut` are equal in length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 4 | Edge ticks of the four reference sources |
| cfgSel | input | 2 | Reference selector |
| cfgMode | input | 2 | 0 two-stage, 1 six-entry table, 2 by-1/2 table, 3 by-2/4 table |
| cfgDivA | input | 3 | First divider field |
| cfgDivB | input | 3 | Second divider field (mode 0 only) |
| cfgGateOff | input | 1 | 1 stops the output, 0 lets it run |
| clkOut | output | 1 | Gated divided clock |

## Verification
The hardest situation to reach is a configuration change that lands inside a low phase after that phase has already counted a tick. From the ports this point cannot be seen directly. The stimulus therefore uses a source that ticks every second cycle and waits for the observed falling edge. It then lets exactly one source tick pass before changing the selector and ratio. Both the remaining low phase and the next high phase must keep the old length, and only the following low phase may show the new one. A similar timed write of the stop bit, a few cycles into a high phase, checks that the pulse is not cut.

// File: rtl/periph_clk_pkg.sv
package periph_clk_pkg;

  typedef enum logic [1:0] {
    MODE_DOUBLE = 2'd0,
    MODE_SIX    = 2'd1,
    MODE_PAIR   = 2'd2,
    MODE_QUAD   = 2'd3
  } divMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // adopt configuration this cycle
    logic gateUpd;  // gate may follow its control bit this cycle
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lowIdle;  // divided clock low, no tick counted yet
    logic divLow;   // divided clock low
  } pathStatus_t;

endpackage

// File: rtl/periph_clk_ctrl.sv
module periph_clk_ctrl
  import periph_clk_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int FIELD_W = 3,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [1:0]         cfgMode,
  input  logic [FIELD_W-1:0] cfgDivA,
  input  logic [FIELD_W-1:0] cfgDivB,
  input  pathStatus_t        status,
  output logic [SEL_W-1:0]   effSel,
  output logic [CNT_W-1:0]   effRatio,
  output logic [SEL_W-1:0]   actSel,
  output logic [CNT_W-1:0]   actRatio,
  output ctrlStrobe_t        strobe
);

  localparam int SIX_TOP = 6;

  logic [CNT_W-1:0] stageA, stageB, cfgRatio;

  // ratio decode from configuration fields
  always_comb begin
    stageA = (cfgDivA == '0) ? CNT_W'(1) : CNT_W'(cfgDivA);
    stageB = (cfgDivB == '0) ? CNT_W'(1) : CNT_W'(cfgDivB);
    case (divMode_e'(cfgMode))
      MODE_DOUBLE: cfgRatio = CNT_W'(stageA * stageB);
      MODE_SIX:    cfgRatio = ((cfgDivA != '0) && (cfgDivA <= FIELD_W'(SIX_TOP)))
                              ? CNT_W'(cfgDivA) : CNT_W'(1);
      MODE_PAIR:   cfgRatio = cfgDivA[0] ? CNT_W'(2) : CNT_W'(1);
      MODE_QUAD:   cfgRatio = cfgDivA[0] ? CNT_W'(4) : CNT_W'(2);
      default:     cfgRatio = CNT_W'(1);
    endcase
  end

  // loading window: divided clock low and nothing counted in this phase
  always_comb begin
    strobe.load    = status.lowIdle;
    strobe.gateUpd = status.divLow;
    effSel         = strobe.load ? cfgSel   : actSel;
    effRatio       = strobe.load ? cfgRatio : actRatio;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel   <= '0;
      actRatio <= CNT_W'(1);
    end else begin
      actSel   <= effSel;
      actRatio <= effRatio;
    end
  end

endmodule

// File: rtl/periph_clk_path.sv
module periph_clk_path
  import periph_clk_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2**SEL_W-1:0] refTick,
  input  logic [SEL_W-1:0]    effSel,
  input  logic [CNT_W-1:0]    effRatio,
  input  logic                gateOff,
  input  ctrlStrobe_t         strobe,
  output pathStatus_t         status,
  output logic                divClk,
  output logic [CNT_W-1:0]    cnt,
  output logic                clkOut
);

  logic tick, lastCnt, divNext, gateOn, gateNext;

  always_comb begin
    tick     = refTick[effSel];
    lastCnt  = (cnt == effRatio - CNT_W'(1));
    divNext  = (tick && lastCnt) ? ~divClk : divClk;
    gateNext = strobe.gateUpd ? ~gateOff : gateOn;
    status.lowIdle = ~divClk && (cnt == '0);
    status.divLow  = ~divClk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      divClk <= 1'b0;
      gateOn <= 1'b0;
      clkOut <= 1'b0;
    end else begin
      if (tick) begin
        cnt <= lastCnt ? '0 : cnt + CNT_W'(1);
      end
      divClk <= divNext;
      gateOn <= gateNext;
      clkOut <= divNext & gateNext;
    end
  end

endmodule

// File: rtl/periph_clk_gen.sv
module periph_clk_gen
  import periph_clk_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int FIELD_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2**SEL_W-1:0] refTick,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [1:0]          cfgMode,
  input  logic [FIELD_W-1:0]  cfgDivA,
  input  logic [FIELD_W-1:0]  cfgDivB,
  input  logic                cfgGateOff,
  output logic                clkOut
);

  localparam int MAX_RATIO = (2**FIELD_W - 1) * (2**FIELD_W - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  ctrlStrobe_t      strobe;
  pathStatus_t      status;
  logic [SEL_W-1:0] effSel, actSel;
  logic [CNT_W-1:0] effRatio, actRatio, cnt;
  logic             divClk;

  periph_clk_ctrl #(.SEL_W(SEL_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgMode(cfgMode),
    .cfgDivA(cfgDivA), .cfgDivB(cfgDivB), .status(status),
    .effSel(effSel), .effRatio(effRatio), .actSel(actSel),
    .actRatio(actRatio), .strobe(strobe)
  );

  periph_clk_path #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .refTick(refTick), .effSel(effSel),
    .effRatio(effRatio), .gateOff(cfgGateOff), .strobe(strobe),
    .status(status), .divClk(divClk), .cnt(cnt), .clkOut(clkOut)
  );

endmodule

// File: rtl/periph_clk_gen_chk.sv
module periph_clk_gen_chk #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkOut,
  input logic             divClk,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] actSel,
  input logic [CNT_W-1:0] actRatio
);

  // R10: selector changes only from an untouched low phase
  a_r10_sel_window: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actSel) |-> $past(!divClk && (cnt == '0)));

  // R10: ratio changes only from an untouched low phase
  a_r10_ratio_window: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actRatio) |-> $past(!divClk && (cnt == '0)));

  // R9: output never falls ahead of the divided clock
  a_r9_no_cut_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOut) |-> $fell(divClk));

  // R8: output only starts a pulse together with the divided clock
  a_r8_whole_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> $rose(divClk));

  // R11: phase counter stays below the active ratio
  a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    rstN |-> (cnt < actRatio));

endmodule

bind periph_clk_gen periph_clk_gen_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkOut(clkOut), .divClk(divClk),
  .cnt(cnt), .actSel(actSel), .actRatio(actRatio)
);

// File: tb/periph_clk_gen_bench.sv
module periph_clk_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] refTick = '0;
  logic [1:0] cfgSel = '0;
  logic [1:0] cfgMode = '0;
  logic [2:0] cfgDivA = 3'd1;
  logic [2:0] cfgDivB = 3'd1;
  logic       cfgGateOff = 1'b0;
  logic       clkOut;

  int cyc = 0;
  int total = 0;
  int failed = 0;

  periph_clk_gen u_periph_clk_gen (
    .clk(clk), .rstN(rstN), .refTick(refTick), .cfgSel(cfgSel),
    .cfgMode(cfgMode), .cfgDivA(cfgDivA), .cfgDivB(cfgDivB),
    .cfgGateOff(cfgGateOff), .clkOut(clkOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source k ticks once every k+1 cycles
  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) refTick[k] = ((cyc % (k + 1)) == 0);
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic waitLevel(input logic v);
    do @(negedge clk); while (clkOut !== v);
  endtask

  task automatic measure(output int hi, output int lo);
    waitLevel(1'b0);
    waitLevel(1'b1);
    hi = 1;
    @(negedge clk);
    while (clkOut === 1'b1) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (clkOut === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic settleMeasure(output int hi, output int lo);
    int h, l;
    measure(h, l);
    measure(hi, lo);
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    repeat (n) begin @(negedge clk); if (clkOut !== 1'b0) highs++; end
  endtask

  function automatic int expRatio(input int mode, input int a, input int b);
    int fa, fb;
    fa = (a == 0) ? 1 : a;
    fb = (b == 0) ? 1 : b;
    case (mode)
      0: return fa * fb;
      1: return (a >= 1 && a <= 6) ? a : 1;
      2: return (a % 2) ? 2 : 1;
      default: return (a % 2) ? 4 : 2;
    endcase
  endfunction

  task automatic setCfg(input int mode, input int sel, input int a, input int b);
    cfgMode = 2'(mode);
    cfgSel  = 2'(sel);
    cfgDivA = 3'(a);
    cfgDivB = 3'(b);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failed++;
    total++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int hi, lo, highs, b, sel, exp;
    string tag;

    repeat (3) @(negedge clk);
    check("R1", "clkOut during reset", int'(clkOut), 0);
    rstN = 1'b1;

    // R2: source order, ratio 1
    for (int s = 0; s < 4; s++) begin
      setCfg(0, s, 1, 1);
      settleMeasure(hi, lo);
      check("R2", "high length per source", hi, s + 1);
      check("R2", "low length per source", lo, s + 1);
    end

    // R3 / R4 / R11: two-stage sweep
    for (int a = 0; a < 8; a++) begin
      for (int bb = 0; bb < 8; bb++) begin
        sel = (a + bb) % 4;
        setCfg(0, sel, a, bb);
        settleMeasure(hi, lo);
        exp = expRatio(0, a, bb) * (sel + 1);
        tag = (a == 0 || bb == 0) ? "R4" : "R3";
        check(tag, "two-stage high length", hi, exp);
        check("R11", "low equals high", lo, hi);
      end
    end

    // R5 / R6 / R7: table modes, second field scrambled
    for (int m = 1; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        b = (a * 5 + 3) % 8;
        sel = (a + m) % 4;
        setCfg(m, sel, a, b);
        settleMeasure(hi, lo);
        exp = expRatio(m, a, b) * (sel + 1);
        tag = (m == 1) ? "R5" : ((m == 2) ? "R6" : "R7");
        check(tag, "table mode high length", hi, exp);
        check(tag, "table mode low length", lo, exp);
      end
    end

    // R8: stop bit holds output low, clearing it resumes
    setCfg(0, 0, 2, 1);
    settleMeasure(hi, lo);
    cfgGateOff = 1'b1;
    repeat (20) @(negedge clk);
    countHigh(200, highs);
    check("R8", "high samples while stopped", highs, 0);
    cfgGateOff = 1'b0;
    settleMeasure(hi, lo);
    check("R8", "high length after restart", hi, 2);

    // R9: stop during a high phase keeps that pulse whole
    setCfg(0, 1, 4, 2);
    settleMeasure(hi, lo);
    check("R9", "reference high length", hi, 16);
    waitLevel(1'b0);
    waitLevel(1'b1);
    hi = 1;
    repeat (4) begin @(negedge clk); if (clkOut === 1'b1) hi++; end
    cfgGateOff = 1'b1;
    @(negedge clk);
    while (clkOut === 1'b1) begin hi++; @(negedge clk); end
    check("R9", "pulse length with stop mid-pulse", hi, 16);
    countHigh(100, highs);
    check("R9", "high samples after stop", highs, 0);
    cfgGateOff = 1'b0;

    // R10: change after a tick of the low phase was counted
    settleMeasure(hi, lo);
    waitLevel(1'b1);
    waitLevel(1'b0);
    lo = 1;
    repeat (2) begin @(negedge clk); lo++; end
    setCfg(0, 0, 1, 1);
    @(negedge clk);
    while (clkOut === 1'b0) begin lo++; @(negedge clk); end
    check("R10", "low phase keeps old ratio", lo, 16);
    hi = 1;
    @(negedge clk);
    while (clkOut === 1'b1) begin hi++; @(negedge clk); end
    check("R10", "next high keeps old ratio", hi, 16);
    lo = 1;
    @(negedge clk);
    while (clkOut === 1'b0) begin lo++; @(negedge clk); end
    check("R10", "following low uses new ratio", lo, 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule